// File: doc/BRIEF.md
# Serial ADC Host Controller

This block is the host side of a link to a small two-input, 8-bit successive-approximation converter with a serial interface. The host raises a request that names one of the two inputs and says whether the conversion is single-ended or differential. The controller then runs one complete frame. It pulls the active-low select line down and produces a serial clock from the system clock. It sends the address, lets the settling slot go by, collects the result and checks it, and then releases the select line.

The converter returns its result twice. It first sends the byte with the most significant bit first. It then sends the same value least significant bit first, and the two copies share bit 0. The controller keeps the first copy as the result. It compares bits 1 to 7 of the second copy against the first and raises a mismatch flag if any of them disagree. After the frame ends, the block refuses new requests until the select line has stayed high for a set number of cycles. This keeps the minimum select-high time between two conversions.

Top module: `serial_adc_host`

## Requirements
- R1: When reset is released, cs_n is high, sclk is low, and busy, done, result and mismatch are all zero.
- R2: A request taken while the block is idle drives cs_n low. sclk is low at that moment. Each sclk period lasts 2*DIV_HALF system clocks, and one frame has exactly 19 rising sclk edges. cs_n stays low from the first of these edges to the last.
- R3: The converter samples mosi on rising sclk edges, and mosi may change only while sclk is low. Rise 1 carries the start bit (1). Rise 2 carries the mode bit (1 = single-ended, 0 = differential). Rise 3 carries the input select (req_chan: 0 = first input, 1 = second).
- R4: The miso value at rise 4 is the settling slot and has no effect on result.
- R5: miso at rises 5 to 12 forms result, most significant bit first.
- R6: miso at rises 13 to 19 carries bits 1 to 7 of the repeated result. mismatch is 1 exactly when any of these bits differs from the same bit of result.
- R7: done is high for one cycle, in the same cycle cs_n rises. result and mismatch become valid with done and keep their value until the next done.
- R8: busy goes high when a request is taken. It stays high until cs_n has been high for CS_GAP cycles. A request made while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Conversion request; taken only when busy is low |
| req_chan | input | 1 | Input select sent as the third address bit |
| req_single | input | 1 | 1 = single-ended, 0 = differential |
| busy | output | 1 | Frame running or select-high gap not yet finished |
| cs_n | output | 1 | Active-low converter select |
| sclk | output | 1 | Serial clock to the converter |
| mosi | output | 1 | Address data to the converter |
| miso | input | 1 | Result data from the converter |
| result | output | DATA_W | Result collected most significant bit first |
| done | output | 1 | One-cycle frame-complete strobe |
| mismatch | output | 1 | Repeated bits disagreed with result |

## Verification
The bench runs a behavioural converter model. The model drives the settling slot high in some frames. A controller that read that slot would return every result shifted by one place. Some frames corrupt a single bit of the repeated copy, so a compare that skipped an index or included the shared bit 0 would get mismatch wrong. The bench sends requests while busy is high and holds the request line high across the gap. This catches a controller that restarts in the middle of a frame or shortens the select-high time. The bench also watches whether mosi changes while sclk is high, and it measures the sclk period and the number of edges in each frame.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
   // start bit plus mode bit plus input select
   localparam int ADDR_SLOTS   = 3;
   localparam int SETTLE_SLOTS = 1;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_GAP  = 2'd2
   } rd_state_e;
endpackage

// File: rtl/adc_rd_tick.sv
module adc_rd_tick #(
   parameter int DIV_HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

   logic [CW-1:0] cnt_q;

   assign tick = run && (cnt_q == CW'(DIV_HALF - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run || tick)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture #(
   parameter int DATA_W    = 8,
   parameter int FIRST_MSB = 5,
   parameter int SLOT_W    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              sample,
   input  logic [SLOT_W-1:0] slot,
   input  logic              miso,
   output logic [DATA_W-1:0] data,
   output logic              mism
);
   localparam int LAST_MSB  = FIRST_MSB + DATA_W - 1;
   localparam int LAST_ECHO = LAST_MSB + DATA_W - 1;
   localparam int IW        = $clog2(DATA_W);

   logic [DATA_W-1:0] data_q;
   logic              mism_q;
   logic              in_msb, in_echo;
   logic [IW-1:0]     echo_idx;

   always_comb begin
      in_msb   = (slot >= SLOT_W'(FIRST_MSB)) && (slot <= SLOT_W'(LAST_MSB));
      in_echo  = (slot >  SLOT_W'(LAST_MSB))  && (slot <= SLOT_W'(LAST_ECHO));
      echo_idx = IW'(slot - SLOT_W'(LAST_MSB));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         mism_q <= 1'b0;
      end else if (clear) begin
         data_q <= '0;
         mism_q <= 1'b0;
      end else if (sample) begin
         if (in_msb)
            data_q <= {data_q[DATA_W-2:0], miso};
         else if (in_echo)
            mism_q <= mism_q | (miso != data_q[echo_idx]);
      end
   end

   assign data = data_q;
   assign mism = mism_q;
endmodule

// File: rtl/serial_adc_host.sv
module serial_adc_host
   import adc_rd_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int DIV_HALF = 4,
   parameter int CS_GAP   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_chan,
   input  logic              req_single,
   output logic              busy,
   output logic              cs_n,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic [DATA_W-1:0] result,
   output logic              done,
   output logic              mismatch
);
   localparam int FIRST_MSB = ADDR_SLOTS + SETTLE_SLOTS + 1;
   localparam int LAST_SLOT = FIRST_MSB + 2 * DATA_W - 2;
   localparam int SLOT_W    = $clog2(LAST_SLOT + 1);
   localparam int GAP_W     = $clog2(CS_GAP + 1);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
      if (DIV_HALF < 1) begin : g_bad_div
         $error("DIV_HALF must be at least 1");
      end
      if (CS_GAP < 1) begin : g_bad_gap
         $error("CS_GAP must be at least 1");
      end
   endgenerate

   rd_state_e         state_q;
   logic              cs_n_q, sclk_q, mosi_q, done_q, mism_q;
   logic              chan_q, single_q;
   logic [SLOT_W-1:0] slot_q;
   logic [GAP_W-1:0]  gap_q;
   logic [DATA_W-1:0] result_q;
   logic              accept, run, tick, sample, next_di;
   logic [DATA_W-1:0] cap_data;
   logic              cap_mism;

   assign accept = (state_q == ST_IDLE) && req_valid;
   assign run    = (state_q == ST_RUN);
   assign sample = tick && !sclk_q;

   always_comb begin
      if (slot_q == SLOT_W'(1))
         next_di = single_q;
      else if (slot_q == SLOT_W'(2))
         next_di = chan_q;
      else
         next_di = 1'b0;
   end

   adc_rd_tick #(.DIV_HALF(DIV_HALF)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .tick (tick)
   );

   adc_rd_capture #(
      .DATA_W   (DATA_W),
      .FIRST_MSB(FIRST_MSB),
      .SLOT_W   (SLOT_W)
   ) u_cap (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (accept),
      .sample(sample),
      .slot  (slot_q + 1'b1),
      .miso  (miso),
      .data  (cap_data),
      .mism  (cap_mism)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         cs_n_q   <= 1'b1;
         sclk_q   <= 1'b0;
         mosi_q   <= 1'b0;
         slot_q   <= '0;
         chan_q   <= 1'b0;
         single_q <= 1'b0;
         gap_q    <= '0;
         result_q <= '0;
         mism_q   <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  state_q  <= ST_RUN;
                  cs_n_q   <= 1'b0;
                  mosi_q   <= 1'b1;
                  slot_q   <= '0;
                  chan_q   <= req_chan;
                  single_q <= req_single;
               end
            end
            ST_RUN: begin
               if (tick) begin
                  if (!sclk_q) begin
                     sclk_q <= 1'b1;
                     slot_q <= slot_q + 1'b1;
                  end else begin
                     sclk_q <= 1'b0;
                     if (slot_q == SLOT_W'(LAST_SLOT)) begin
                        cs_n_q   <= 1'b1;
                        done_q   <= 1'b1;
                        result_q <= cap_data;
                        mism_q   <= cap_mism;
                        mosi_q   <= 1'b0;
                        gap_q    <= '0;
                        state_q  <= ST_GAP;
                     end else begin
                        mosi_q <= next_di;
                     end
                  end
               end
            end
            ST_GAP: begin
               if (gap_q == GAP_W'(CS_GAP - 1))
                  state_q <= ST_IDLE;
               else
                  gap_q <= gap_q + 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (state_q != ST_IDLE);
   assign cs_n     = cs_n_q;
   assign sclk     = sclk_q;
   assign mosi     = mosi_q;
   assign result   = result_q;
   assign done     = done_q;
   assign mismatch = mism_q;
endmodule

// File: rtl/serial_adc_host_chk.sv
module serial_adc_host_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              busy,
   input logic              cs_n,
   input logic              sclk,
   input logic              mosi,
   input logic [DATA_W-1:0] result,
   input logic              done,
   input logic              mismatch
);
   // R2
   sclk_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);

   // R3
   di_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> $stable(mosi));

   // R7
   done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $rose(cs_n));

   // R7
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(result) && $stable(mismatch)));

   // R8
   accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req_valid) |=> (!cs_n && busy));

   // R8
   release_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> busy);

   // R8
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> !$past(busy));
endmodule

bind serial_adc_host serial_adc_host_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_serial_adc_host.sv
`timescale 1ns/1ps
module tb_serial_adc_host;
   localparam int DATA_W   = 8;
   localparam int DIV_HALF = 3;
   localparam int CS_GAP   = 5;
   localparam int RISES    = 19;
   localparam time PER     = 2 * DIV_HALF * 4;
   localparam int NVEC     = 6;
   // {chan, single, code[7:0], flip[7:0], settle}
   localparam logic [18:0] VEC [0:NVEC-1] = '{
      {1'b0, 1'b1, 8'h00, 8'h00, 1'b0},
      {1'b1, 1'b1, 8'hFF, 8'h00, 1'b1},
      {1'b0, 1'b0, 8'hA5, 8'h00, 1'b1},
      {1'b1, 1'b0, 8'h5A, 8'h80, 1'b0},
      {1'b0, 1'b1, 8'h3C, 8'h02, 1'b0},
      {1'b1, 1'b1, 8'h81, 8'h00, 1'b1}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_chan = 1'b0, req_single = 1'b0;
   logic busy, cs_n, sclk, mosi, done, mismatch;
   logic miso = 1'b1;
   logic [DATA_W-1:0] result;

   int checks = 0, errors = 0, cycles = 0;
   int rises = 0, frames = 0, per_bad = 0, di_bad = 0, hi_cnt = 0, last_gap = 0;
   time last_rise = 0;
   logic [2:0] addr_seen = '0;
   logic [7:0] mdl_code = '0, mdl_flip = '0;
   logic mdl_settle = 1'b0;
   logic prev_sclk = 1'b0, prev_mosi = 1'b0;

   always #2 clk = ~clk;

   serial_adc_host #(.DATA_W(DATA_W), .DIV_HALF(DIV_HALF), .CS_GAP(CS_GAP)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
      .req_single(req_single), .busy(busy), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
      .miso(miso), .result(result), .done(done), .mismatch(mismatch));

   // converter model: edge counter and address capture
   always @(posedge sclk or negedge cs_n) begin
      if (!sclk) begin
         rises = 0;
         frames++;
      end else if (!cs_n) begin
         rises++;
         if (rises <= 3) addr_seen[3 - rises] = mosi;
         if (rises > 1 && ($time - last_rise) != PER) per_bad++;
         last_rise = $time;
      end
   end

   // converter model: data output on falling edges
   always @(negedge sclk or posedge cs_n) begin
      if (cs_n) miso = 1'b1;
      else if (rises == 3) miso = mdl_settle;
      else if (rises >= 4 && rises <= 11) miso = mdl_code[11 - rises];
      else if (rises >= 12 && rises <= 18) miso = mdl_code[rises - 11] ^ mdl_flip[rises - 11];
   end

   always @(posedge clk) begin
      if (cs_n) hi_cnt++;
      else hi_cnt = 0;
   end
   always @(negedge cs_n) last_gap = hi_cnt;

   always @(negedge clk) begin
      if (prev_sclk && sclk && !cs_n && (mosi !== prev_mosi)) di_bad++;
      prev_sclk = sclk;
      prev_mosi = mosi;
   end

   task automatic report();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles >= 190000) begin
         errors++;
         $display("FAIL watchdog expired");
         report();
      end
   end

   task automatic check(input string req, input string what, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wait_done();
      int n = 0;
      while (done !== 1'b1 && n < 3000) begin
         @(negedge clk);
         n++;
      end
      check("R7", "done seen", {31'd0, done}, 32'd1);
   endtask

   task automatic frame_checks(input logic chan, input logic single, input logic [7:0] code,
                               input logic [7:0] flip, input int f0);
      check("R5", "result", {24'd0, result}, {24'd0, code});
      check("R6", "mismatch", {31'd0, mismatch}, {31'd0, |flip[7:1]});
      check("R3", "address bits", {29'd0, addr_seen}, {29'd0, 1'b1, single, chan});
      check("R2", "rising edges", rises, RISES);
      check("R2", "sclk period errors", per_bad, 0);
      check("R3", "mosi moved while sclk high", di_bad, 0);
      check("R8", "frames started", frames, f0 + 1);
      check("R8", "busy at done", {31'd0, busy}, 32'd1);
   endtask

   task automatic gap_checks(input logic [7:0] code);
      @(negedge clk);
      check("R7", "done one cycle", {31'd0, done}, 32'd0);
      repeat (CS_GAP - 2) @(negedge clk);
      check("R8", "busy through gap", {31'd0, busy}, 32'd1);
      @(negedge clk);
      check("R8", "busy released", {31'd0, busy}, 32'd0);
      check("R7", "result held", {24'd0, result}, {24'd0, code});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", "cs_n", {31'd0, cs_n}, 32'd1);
      check("R1", "sclk", {31'd0, sclk}, 32'd0);
      check("R1", "busy", {31'd0, busy}, 32'd0);
      check("R1", "done", {31'd0, done}, 32'd0);
      check("R1", "result", {24'd0, result}, 32'd0);
      check("R1", "mismatch", {31'd0, mismatch}, 32'd0);

      // table of vectors: R4 settle slot driven high in some, R6 corrupt echo in some
      for (int i = 0; i < NVEC; i++) begin
         int f0;
         logic [18:0] v;
         v = VEC[i];
         mdl_code = v[16:9];
         mdl_flip = v[8:1];
         mdl_settle = v[0];
         f0 = frames;
         req_chan = v[18];
         req_single = v[17];
         req_valid = 1'b1;
         @(negedge clk);
         req_valid = 1'b0;
         check("R2", "cs_n low after accept", {31'd0, cs_n}, 32'd0);
         check("R2", "sclk low at select", {31'd0, sclk}, 32'd0);
         wait_done();
         frame_checks(v[18], v[17], v[16:9], v[8:1], f0);
         check("R4", "settle slot ignored", {24'd0, result}, {24'd0, v[16:9]});
         gap_checks(v[16:9]);
      end

      // R8: requests while busy are ignored
      begin
         int f0;
         mdl_code = 8'h6E; mdl_flip = 8'h00; mdl_settle = 1'b1;
         f0 = frames;
         req_chan = 1'b0; req_single = 1'b0; req_valid = 1'b1;
         @(negedge clk);
         req_chan = 1'b1; req_single = 1'b1;
         repeat (40) @(negedge clk);
         req_valid = 1'b0;
         wait_done();
         frame_checks(1'b0, 1'b0, 8'h6E, 8'h00, f0);
         gap_checks(8'h6E);
      end

      // R8: request held high across the gap, back-to-back frames
      begin
         int f0;
         mdl_code = 8'hC3; mdl_flip = 8'h00; mdl_settle = 1'b0;
         f0 = frames;
         req_chan = 1'b1; req_single = 1'b0; req_valid = 1'b1;
         @(negedge clk);
         wait_done();
         check("R5", "first result", {24'd0, result}, 32'hC3);
         @(negedge clk);
         mdl_code = 8'h17; mdl_flip = 8'h40;
         wait_done();
         req_valid = 1'b0;
         check("R8", "two frames", frames, f0 + 2);
         check("R8", "select high gap", (last_gap >= CS_GAP) ? 1 : 0, 1);
         check("R5", "second result", {24'd0, result}, 32'h17);
         check("R6", "second mismatch", {31'd0, mismatch}, 32'd1);
      end

      repeat (10) @(negedge clk);
      report();
   end
endmodule